// File: doc/BRIEF.md
# Alarm-Driven Power-Enable Sequencer

This block owns the enable line of an external power regulator. Software arms it through a control register: one bit hands the line over to the block, and two small fields choose, for each external wake input, whether that input is allowed to wake the system and which level counts as active. While armed, a pulse from the second alarm comparator drops the line to OFF. Once OFF, an enabled wake input seen at its active level, or a first-alarm pulse whose interrupt is enabled, raises the line to ON again.

The block also holds the second alarm's sticky status flag, a sticky wake-event flag and the interrupt enables for both alarms. It drives an interrupt output from the second alarm's flag and enable. The alarm comparators sit outside the block and each delivers a one-cycle pulse. Wake inputs are asynchronous and pass through a two-flop synchronizer. Debouncing is left to the board.

Top module: `pwr_seq_top`

## Requirements
- R1: After reset the power-enable output is 1 (ON). The control register at 0x98 reads 0x000000F0, with every input active-low. Status at 0x44, interrupt enable at 0x48 and the interrupt output are all 0.
- R2: While control bit 16 is 0, the power-enable output stays ON, even when a second-alarm pulse arrives.
- R3: With bit 16 at 1, a second-alarm pulse sampled on a clock edge makes the output OFF (0) after that edge.
- R4: A second-alarm pulse sets status bit 7. Writing 1 to that bit clears it and writing 0 leaves it. A new pulse wins over a clear in the same cycle.
- R5: The interrupt output equals status bit 7 ANDed with interrupt-enable bit 4.
- R6: Control bits 0..3 enable wake inputs 0..3. Control bits 4..7 give each input's polarity: 1 means the input wakes at level 0, and 0 means it wakes at level 1.
- R7: While OFF, an enabled wake input at its active level makes the output ON on the third rising edge after the input changes (two synchronizer flops, then the state flop). The same event sets the sticky status bit 0, which clears when 1 is written to it.
- R8: A disabled wake input, or an enabled one at its inactive level, leaves the output OFF and status bit 0 clear.
- R9: While OFF, a first-alarm pulse makes the output ON after that edge if interrupt-enable bit 3 is 1. If the bit is 0, the pulse has no effect.
- R10: Clearing control bit 16 while OFF makes the output ON on the edge after the write.
- R11: A first-alarm pulse with bit 3 enabled that coincides with a second-alarm pulse keeps the output ON.
- R12: Writes to unmapped addresses change nothing. Unused control bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 8 | Byte address for write and read |
| regWData | input | 32 | Write data |
| regRData | output | 32 | Read data (combinational from regAddr) |
| alarm1Pulse | input | 1 | One-cycle first-alarm match pulse |
| alarm2Pulse | input | 1 | One-cycle second-alarm match pulse |
| wakeIn | input | 4 | Asynchronous external wake inputs |
| pwrEnOut | output | 1 | Power-enable to regulator, 1 = ON |
| alarm2Irq | output | 1 | Second-alarm interrupt |

## Verification
The bench builds the block with its defaults: four wake inputs and a two-stage synchronizer. With four inputs it can drive a disabled input and an enabled input at the same time, and it can exercise both polarities on separate pins. With two stages, the three-edge wake latency can be counted exactly, and the bench checks that the output is still OFF one edge before it rises.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_STATUS = 8'h44;
  localparam logic [ADDR_W-1:0] ADDR_IRQEN  = 8'h48;
  localparam logic [ADDR_W-1:0] ADDR_PWRCTL = 8'h98;

  localparam int STAT_ALARM2_BIT = 7;
  localparam int STAT_WAKE_BIT   = 0;
  localparam int IE_ALARM2_BIT   = 4;
  localparam int IE_ALARM1_BIT   = 3;
  localparam int CTL_OWN_BIT     = 16;

  typedef struct packed {
    logic goOn;
    logic goOff;
    logic setWake;
  } seqStrobes_t;
endpackage

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pwrOn,
  input  logic        ctrlOwn,
  input  logic        wakeHit,
  input  logic        alarm1Armed,
  input  logic        alarm2Pulse,
  output seqStrobes_t strobes
);
  always_comb begin
    strobes.goOff   = pwrOn && ctrlOwn && alarm2Pulse && !alarm1Armed;
    strobes.goOn    = !pwrOn && (!ctrlOwn || wakeHit || alarm1Armed);
    strobes.setWake = !pwrOn && wakeHit;
  end

  // R11: an armed first alarm must never let the line drop
  a_r11_alarm1_holds_on: assert property (@(posedge clk) disable iff (!rstN)
    (pwrOn && alarm1Armed) |=> pwrOn);
  // R8: no wake flag unless a wake hit was seen
  a_r8_wake_needs_hit: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setWake |-> wakeHit);
endmodule

// File: rtl/pwr_seq_dp.sv
module pwr_seq_dp
  import pwr_seq_pkg::*;
#(
  parameter int WAKE_COUNT  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWr,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [DATA_W-1:0]     regWData,
  output logic [DATA_W-1:0]     regRData,
  input  logic                  alarm1Pulse,
  input  logic                  alarm2Pulse,
  input  logic [WAKE_COUNT-1:0] wakeIn,
  input  seqStrobes_t           strobes,
  output logic                  pwrOn,
  output logic                  ctrlOwn,
  output logic                  wakeHit,
  output logic                  alarm1Armed,
  output logic                  alarm2Irq
);
  localparam int POL_LO = WAKE_COUNT;
  localparam int POL_HI = 2 * WAKE_COUNT - 1;

  logic [WAKE_COUNT-1:0] wakeEn, wakePol, hitVec;
  logic [SYNC_STAGES-1:0][WAKE_COUNT-1:0] syncQ;
  logic alarm2Flag, wakeFlag, ieAlarm1, ieAlarm2;
  logic wrCtl, wrStat, wrIe;

  assign wrCtl  = regWr && (regAddr == ADDR_PWRCTL);
  assign wrStat = regWr && (regAddr == ADDR_STATUS);
  assign wrIe   = regWr && (regAddr == ADDR_IRQEN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlOwn <= 1'b0;
      wakeEn  <= '0;
      wakePol <= '1;
      ieAlarm1 <= 1'b0;
      ieAlarm2 <= 1'b0;
    end else begin
      if (wrCtl) begin
        ctrlOwn <= regWData[CTL_OWN_BIT];
        wakeEn  <= regWData[WAKE_COUNT-1:0];
        wakePol <= regWData[POL_HI:POL_LO];
      end
      if (wrIe) begin
        ieAlarm1 <= regWData[IE_ALARM1_BIT];
        ieAlarm2 <= regWData[IE_ALARM2_BIT];
      end
    end
  end

  // synchronizer chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= '0;
    else       syncQ[0] <= wakeIn;
  end
  generate
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= '0;
        else       syncQ[s] <= syncQ[s-1];
      end
    end
    for (genvar w = 0; w < WAKE_COUNT; w++) begin : g_wake
      assign hitVec[w] = wakeEn[w] & (syncQ[SYNC_STAGES-1][w] ^ wakePol[w]);
    end
  endgenerate

  assign wakeHit     = |hitVec;
  assign alarm1Armed = alarm1Pulse && ieAlarm1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarm2Flag <= 1'b0;
      wakeFlag   <= 1'b0;
      pwrOn      <= 1'b1;
    end else begin
      alarm2Flag <= (alarm2Flag && !(wrStat && regWData[STAT_ALARM2_BIT])) || alarm2Pulse;
      wakeFlag   <= (wakeFlag && !(wrStat && regWData[STAT_WAKE_BIT])) || strobes.setWake;
      if (strobes.goOn)       pwrOn <= 1'b1;
      else if (strobes.goOff) pwrOn <= 1'b0;
    end
  end

  assign alarm2Irq = alarm2Flag && ieAlarm2;

  always_comb begin
    regRData = '0;
    case (regAddr)
      ADDR_PWRCTL: begin
        regRData[CTL_OWN_BIT]     = ctrlOwn;
        regRData[WAKE_COUNT-1:0]  = wakeEn;
        regRData[POL_HI:POL_LO]   = wakePol;
      end
      ADDR_STATUS: begin
        regRData[STAT_ALARM2_BIT] = alarm2Flag;
        regRData[STAT_WAKE_BIT]   = wakeFlag;
      end
      ADDR_IRQEN: begin
        regRData[IE_ALARM1_BIT]   = ieAlarm1;
        regRData[IE_ALARM2_BIT]   = ieAlarm2;
      end
      default: regRData = '0;
    endcase
  end

  a_r2_on_when_released: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlOwn |=> pwrOn);
  a_r3_fall_cause: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pwrOn) |-> $past(ctrlOwn && alarm2Pulse));
  a_r7_rise_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwrOn) |-> $past(!ctrlOwn || wakeHit || alarm1Armed));
  a_r4_flag_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarm2Flag) |-> $past(alarm2Pulse));
  a_r7_wake_flag_off_only: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeFlag) |-> $past(!pwrOn));
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int WAKE_COUNT  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWr,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [DATA_W-1:0]     regWData,
  output logic [DATA_W-1:0]     regRData,
  input  logic                  alarm1Pulse,
  input  logic                  alarm2Pulse,
  input  logic [WAKE_COUNT-1:0] wakeIn,
  output logic                  pwrEnOut,
  output logic                  alarm2Irq
);
  seqStrobes_t strobes;
  logic pwrOn, ctrlOwn, wakeHit, alarm1Armed;

  pwr_seq_dp #(.WAKE_COUNT(WAKE_COUNT), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWData(regWData), .regRData(regRData), .alarm1Pulse(alarm1Pulse),
    .alarm2Pulse(alarm2Pulse), .wakeIn(wakeIn), .strobes(strobes),
    .pwrOn(pwrOn), .ctrlOwn(ctrlOwn), .wakeHit(wakeHit),
    .alarm1Armed(alarm1Armed), .alarm2Irq(alarm2Irq)
  );

  pwr_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pwrOn(pwrOn), .ctrlOwn(ctrlOwn),
    .wakeHit(wakeHit), .alarm1Armed(alarm1Armed),
    .alarm2Pulse(alarm2Pulse), .strobes(strobes)
  );

  assign pwrEnOut = pwrOn;
endmodule

// File: tb/pwr_seq_top_bench.sv
`timescale 1ns/1ps
module pwr_seq_top_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic [31:0] regWData = '0;
  logic [31:0] regRData;
  logic alarm1Pulse = 1'b0, alarm2Pulse = 1'b0;
  logic [3:0] wakeIn = 4'b1110;
  logic pwrEnOut, alarm2Irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwr_seq_top u_pwr_seq_top (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWData(regWData), .regRData(regRData), .alarm1Pulse(alarm1Pulse),
    .alarm2Pulse(alarm2Pulse), .wakeIn(wakeIn), .pwrEnOut(pwrEnOut),
    .alarm2Irq(alarm2Irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWData = d;
    @(posedge clk);
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRData;
  endtask

  task automatic pulse2();
    @(negedge clk); alarm2Pulse = 1'b1;
    @(negedge clk); alarm2Pulse = 1'b0;
  endtask

  task automatic pulse1();
    @(negedge clk); alarm1Pulse = 1'b1;
    @(negedge clk); alarm1Pulse = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 pwrEn", {31'b0, pwrEnOut}, 1);
    check("R1 irq", {31'b0, alarm2Irq}, 0);
    rd(8'h98, d); check("R1 ctrl", d, 32'h000000F0);
    rd(8'h44, d); check("R1 status", d, 0);
    rd(8'h48, d); check("R1 irqen", d, 0);
  endtask

  task automatic t_released();
    logic [31:0] d;
    pulse2();
    check("R2 on while released", {31'b0, pwrEnOut}, 1);
    rd(8'h44, d); check("R4 flag set", d, 32'h80);
    wr(8'h44, 32'h0);
    rd(8'h44, d); check("R4 write0 keeps", d, 32'h80);
    wr(8'h44, 32'h80);
    rd(8'h44, d); check("R4 write1 clears", d, 0);
    // set beats clear in the same cycle
    @(negedge clk);
    regWr = 1'b1; regAddr = 8'h44; regWData = 32'h80; alarm2Pulse = 1'b1;
    @(negedge clk);
    regWr = 1'b0; alarm2Pulse = 1'b0;
    rd(8'h44, d); check("R4 set wins", d, 32'h80);
    wr(8'h44, 32'h80);
  endtask

  task automatic t_irq();
    wr(8'h48, 32'h10);
    pulse2();
    check("R5 irq on", {31'b0, alarm2Irq}, 1);
    wr(8'h44, 32'h80);
    check("R5 irq cleared", {31'b0, alarm2Irq}, 0);
    wr(8'h48, 32'h0);
    pulse2();
    check("R5 irq masked", {31'b0, alarm2Irq}, 0);
    wr(8'h44, 32'h80);
  endtask

  task automatic t_wake_high();
    logic [31:0] d;
    wr(8'h98, 32'h000100E1);
    rd(8'h98, d); check("R12 ctrl readback", d, 32'h000100E1);
    pulse2();
    check("R3 off after alarm2", {31'b0, pwrEnOut}, 0);
    @(negedge clk); wakeIn[0] = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R7 still off before sync", {31'b0, pwrEnOut}, 0);
    @(posedge clk); #1;
    check("R7 on after 3 edges", {31'b0, pwrEnOut}, 1);
    rd(8'h44, d); check("R7 wake flag", d, 32'h81);
    wr(8'h44, 32'h81);
    rd(8'h44, d); check("R7 wake flag cleared", d, 0);
    @(negedge clk); wakeIn[0] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    pulse2();
    wr(8'h44, 32'h80);
    @(negedge clk); wakeIn[2] = 1'b0;
    repeat (6) @(negedge clk);
    check("R8 disabled input ignored", {31'b0, pwrEnOut}, 0);
    rd(8'h44, d); check("R8 no wake flag", d, 0);
  endtask

  task automatic t_wake_low();
    logic [31:0] d;
    wr(8'h98, 32'h000100F2);
    repeat (4) @(negedge clk);
    check("R6 inactive high level keeps off", {31'b0, pwrEnOut}, 0);
    @(negedge clk); wakeIn[1] = 1'b0;
    repeat (3) @(posedge clk); #1;
    check("R6 active-low input wakes", {31'b0, pwrEnOut}, 1);
    wr(8'h44, 32'h01);
    @(negedge clk); wakeIn[1] = 1'b1; wakeIn[2] = 1'b1;
    repeat (3) @(negedge clk);
    rd(8'h44, d); check("R7 flag clear", d, 0);
  endtask

  task automatic t_alarm1();
    wr(8'h48, 32'h08);
    pulse2();
    check("R9 off", {31'b0, pwrEnOut}, 0);
    pulse1();
    check("R9 alarm1 enabled wakes", {31'b0, pwrEnOut}, 1);
    wr(8'h48, 32'h0);
    pulse2();
    pulse1();
    check("R9 alarm1 masked ignored", {31'b0, pwrEnOut}, 0);
    wr(8'h48, 32'h08);
    pulse1();
    wr(8'h44, 32'h80);
    @(negedge clk); alarm1Pulse = 1'b1; alarm2Pulse = 1'b1;
    @(negedge clk); alarm1Pulse = 1'b0; alarm2Pulse = 1'b0;
    check("R11 alarm1 beats alarm2", {31'b0, pwrEnOut}, 1);
    wr(8'h44, 32'h80);
    wr(8'h48, 32'h0);
  endtask

  task automatic t_release_off();
    pulse2();
    check("R10 off", {31'b0, pwrEnOut}, 0);
    wr(8'h98, 32'h000000F2);
    check("R10 not yet on", {31'b0, pwrEnOut}, 0);
    @(posedge clk); #1;
    check("R10 on after release", {31'b0, pwrEnOut}, 1);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(8'h50, 32'hFFFFFFFF);
    rd(8'h98, d); check("R12 unmapped write", d, 32'h000000F2);
    wr(8'h98, 32'hFFFFFFFF);
    rd(8'h98, d); check("R12 reserved zero", d, 32'h000100FF);
    rd(8'h48, d); check("R12 irqen untouched", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_released();
    t_irq();
    t_wake_high();
    t_ignored();
    t_wake_low();
    t_alarm1();
    t_release_off();
    t_regs();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule